// File: doc/BRIEF.md
# In-order Pipeline Interlock Controller

This block decides, every cycle, which stages of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) must hold their contents and where empty slots have to be injected. The pipeline it serves has no forwarding paths and single-cycle stages whose memory accesses never miss. The controller is purely a control unit. It sees the decode instruction's two source register numbers with their use bits, the destination register and valid bit of each older stage, a branch flag for the fetched instruction, and the resolution result from execute. From these it drives hold, bubble and redirect controls.

Read-after-write checking sits in decode. A consumer waits there until its producer has reached writeback. Because the register file writes early in the cycle and reads late, a producer that is in writeback does not hold the consumer back. Once a branch has been fetched, no further instruction enters fetch until execute resolves the branch. On a taken branch, the program counter is redirected in that same resolve cycle.

The surrounding pipeline lets its program counter advance only when both `if_hold_o` and `if_bubble_o` are low, or when `pc_redirect_o` is high.

Top module: `pipe_ilk_ctrl`

## Requirements
- R1: After reset, with every valid input low, all outputs are low.
- R2: A decode stall (`if_hold_o`, `id_hold_o` and `ex_bubble_o` all 1) occurs when the decode instruction is valid and an enabled, nonzero source equals the destination of a valid instruction in execute or memory.
- R3: A match against the writeback destination alone causes no stall.
- R4: No stall arises from source register 0, from a source whose use bit is 0, from an invalid older stage, or from an invalid decode instruction.
- R5: During a decode stall `if_bubble_o` is 0, because fetch and decode keep their contents.
- R6: A valid branch in fetch with no decode stall asserts `if_bubble_o` in that cycle.
- R7: After a branch leaves fetch, `if_bubble_o` stays 1 until the cycle in which `ex_br_resolved_i` is 1, and it is 0 in that cycle. A decode stall during this wait suppresses the bubble for as long as it lasts.
- R8: `pc_redirect_o` is 1 exactly when `ex_br_resolved_i` and `ex_br_taken_i` are both 1.
- R9: A branch that meets no decode stall yields exactly two cycles with `if_bubble_o` high.
- R10: A branch held in fetch by a decode stall does not start the wait. The wait starts in the cycle after the stall clears and the branch moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_valid_i | input | 1 | Fetch stage holds an instruction |
| if_is_branch_i | input | 1 | Fetched instruction is a branch |
| id_valid_i | input | 1 | Decode stage holds an instruction |
| id_rs1_i | input | REG_AW | First source register |
| id_rs1_en_i | input | 1 | First source is read |
| id_rs2_i | input | REG_AW | Second source register |
| id_rs2_en_i | input | 1 | Second source is read |
| ex_valid_i | input | 1 | Execute stage valid |
| ex_rd_i | input | REG_AW | Execute destination |
| mem_valid_i | input | 1 | Memory stage valid |
| mem_rd_i | input | REG_AW | Memory destination |
| wb_valid_i | input | 1 | Writeback stage valid |
| wb_rd_i | input | REG_AW | Writeback destination |
| ex_br_resolved_i | input | 1 | Branch in execute resolves this cycle |
| ex_br_taken_i | input | 1 | Resolved branch is taken |
| if_hold_o | output | 1 | Fetch register and PC hold |
| id_hold_o | output | 1 | Decode register holds |
| ex_bubble_o | output | 1 | Load an empty slot into execute |
| if_bubble_o | output | 1 | Fetch slot is empty and the PC does not advance |
| pc_redirect_o | output | 1 | Load the branch target into the PC |

## Verification
The dependence check is swept over every pairing of source and destination numbers 0 to 7. The sweep covers each older stage, each source slot, and every combination of use bit and stage valid bit. It therefore separates true matches from near misses, shows that register 0 is excluded, shows that execute and memory stall while writeback does not, and shows that the two source slots are independent. Branch sequences are run as taken and not taken. One branch is held in fetch by a decode stall, and one meets a stall while it waits in decode. These cases separate the correct two-cycle freeze from an early release, a late release, or a freeze that starts too soon.

// File: rtl/pipe_ilk_pkg.sv
package pipe_ilk_pkg;
  // older stages scanned by the dependence check, youngest first
  typedef enum logic [1:0] {
    STG_EX  = 2'd0,
    STG_MEM = 2'd1,
    STG_WB  = 2'd2
  } older_stg_e;

  localparam int unsigned NUM_OLDER = 3;
  localparam int unsigned NUM_SRC   = 2;
endpackage

// File: rtl/raw_hazard_detect.sv
module raw_hazard_detect
  import pipe_ilk_pkg::*;
#(
  parameter int unsigned REG_AW         = 5,
  parameter bit          RF_WRITE_FIRST = 1'b1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           id_valid_i,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] src_i,
  input  logic [NUM_SRC-1:0]             src_en_i,
  input  logic [NUM_OLDER-1:0]           old_valid_i,
  input  logic [NUM_OLDER-1:0][REG_AW-1:0] old_rd_i,
  output logic                           stall_o
);
  logic [NUM_OLDER-1:0][NUM_SRC-1:0] hit;
  logic [NUM_OLDER-1:0]              stage_hit;

  for (genvar s = 0; s < NUM_OLDER; s++) begin : g_stg
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      assign hit[s][k] = src_en_i[k] && (src_i[k] != '0) && old_valid_i[s]
                         && (old_rd_i[s] == src_i[k]);
    end
    if (s == int'(STG_WB) && RF_WRITE_FIRST) begin : g_wb_free
      // write-then-read register file: result visible in same cycle
      assign stage_hit[s] = 1'b0;
    end else begin : g_counts
      assign stage_hit[s] = |hit[s];
    end
  end

  assign stall_o = id_valid_i && (|stage_hit);

  // R2
  ex_match_stalls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && src_en_i[0] && src_i[0] != '0 && old_valid_i[0]
     && old_rd_i[0] == src_i[0]) |-> stall_o);
  // R3
  wb_only_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RF_WRITE_FIRST && !(old_valid_i[0] || old_valid_i[1])) |-> !stall_o);
  // R4
  invalid_id_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> id_valid_i);
endmodule

// File: rtl/branch_freeze.sv
module branch_freeze (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic if_br_i,
  input  logic id_stall_i,
  input  logic resolved_i,
  output logic block_o
);
  logic wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     wait_q <= 1'b0;
    else if (if_br_i && !id_stall_i) wait_q <= 1'b1;
    else if (resolved_i)             wait_q <= 1'b0;
  end

  assign block_o = if_br_i || (wait_q && !resolved_i);

  // R7
  freeze_after_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_br_i && !id_stall_i) |=> (block_o || resolved_i));
  // R6
  branch_in_fetch_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_br_i |-> block_o);
endmodule

// File: rtl/ilk_merge.sv
module ilk_merge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dep_stall_i,
  input  logic fetch_block_i,
  input  logic resolved_i,
  input  logic taken_i,
  output logic if_hold_o,
  output logic id_hold_o,
  output logic ex_bubble_o,
  output logic if_bubble_o,
  output logic pc_redirect_o
);
  assign if_hold_o     = dep_stall_i;
  assign id_hold_o     = dep_stall_i;
  assign ex_bubble_o   = dep_stall_i;
  // a held fetch slot keeps its instruction, no empty slot then
  assign if_bubble_o   = fetch_block_i && !dep_stall_i;
  assign pc_redirect_o = resolved_i && taken_i;

  // R5
  hold_no_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_hold_o |-> !if_bubble_o);
  // R8
  redirect_needs_resolve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_redirect_o |-> resolved_i);
endmodule

// File: rtl/pipe_ilk_ctrl.sv
module pipe_ilk_ctrl
  import pipe_ilk_pkg::*;
#(
  parameter int unsigned REG_AW         = 5,
  parameter bit          RF_WRITE_FIRST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              if_valid_i,
  input  logic              if_is_branch_i,
  input  logic              id_valid_i,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic              id_rs1_en_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_rs2_en_i,
  input  logic              ex_valid_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              mem_valid_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              wb_valid_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              ex_br_resolved_i,
  input  logic              ex_br_taken_i,
  output logic              if_hold_o,
  output logic              id_hold_o,
  output logic              ex_bubble_o,
  output logic              if_bubble_o,
  output logic              pc_redirect_o
);
  logic [NUM_SRC-1:0][REG_AW-1:0]   src;
  logic [NUM_SRC-1:0]               src_en;
  logic [NUM_OLDER-1:0]             old_valid;
  logic [NUM_OLDER-1:0][REG_AW-1:0] old_rd;
  logic                             dep_stall;
  logic                             fetch_block;

  assign src       = {id_rs2_i, id_rs1_i};
  assign src_en    = {id_rs2_en_i, id_rs1_en_i};
  assign old_valid = {wb_valid_i, mem_valid_i, ex_valid_i};
  assign old_rd    = {wb_rd_i, mem_rd_i, ex_rd_i};

  raw_hazard_detect #(
    .REG_AW         (REG_AW),
    .RF_WRITE_FIRST (RF_WRITE_FIRST)
  ) i_raw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .id_valid_i  (id_valid_i),
    .src_i       (src),
    .src_en_i    (src_en),
    .old_valid_i (old_valid),
    .old_rd_i    (old_rd),
    .stall_o     (dep_stall)
  );

  branch_freeze i_brf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .if_br_i    (if_valid_i && if_is_branch_i),
    .id_stall_i (dep_stall),
    .resolved_i (ex_br_resolved_i),
    .block_o    (fetch_block)
  );

  ilk_merge i_merge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dep_stall_i   (dep_stall),
    .fetch_block_i (fetch_block),
    .resolved_i    (ex_br_resolved_i),
    .taken_i       (ex_br_taken_i),
    .if_hold_o     (if_hold_o),
    .id_hold_o     (id_hold_o),
    .ex_bubble_o   (ex_bubble_o),
    .if_bubble_o   (if_bubble_o),
    .pc_redirect_o (pc_redirect_o)
  );
endmodule

// File: tb/test_pipe_ilk_ctrl.sv
module test_pipe_ilk_ctrl;
  localparam int unsigned AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_valid, if_br, id_valid, rs1_en, rs2_en;
  logic [AW-1:0] rs1, rs2, ex_rd, mem_rd, wb_rd;
  logic ex_valid, mem_valid, wb_valid, resolved, taken;
  logic if_hold, id_hold, ex_bubble, if_bubble, redirect;
  int   checks = 0;
  int   errors = 0;

  always #2 clk = ~clk;

  pipe_ilk_ctrl #(.REG_AW(AW)) i_pipe_ilk_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .if_valid_i(if_valid), .if_is_branch_i(if_br),
    .id_valid_i(id_valid),
    .id_rs1_i(rs1), .id_rs1_en_i(rs1_en), .id_rs2_i(rs2), .id_rs2_en_i(rs2_en),
    .ex_valid_i(ex_valid), .ex_rd_i(ex_rd),
    .mem_valid_i(mem_valid), .mem_rd_i(mem_rd),
    .wb_valid_i(wb_valid), .wb_rd_i(wb_rd),
    .ex_br_resolved_i(resolved), .ex_br_taken_i(taken),
    .if_hold_o(if_hold), .id_hold_o(id_hold), .ex_bubble_o(ex_bubble),
    .if_bubble_o(if_bubble), .pc_redirect_o(redirect)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    if_valid = 0; if_br = 0; id_valid = 0; rs1 = 0; rs2 = 0; rs1_en = 0; rs2_en = 0;
    ex_valid = 0; mem_valid = 0; wb_valid = 0; ex_rd = 0; mem_rd = 0; wb_rd = 0;
    resolved = 0; taken = 0;
  endtask

  // drive at negedge, sample 1 ns later (well before next posedge)
  task automatic step();
    @(negedge clk);
  endtask

  task automatic check_stall(input string req, input logic exp);
    chk(req, if_hold, exp);
    chk(req, id_hold, exp);
    chk(req, ex_bubble, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(); #1;
    // R1 reset state
    check_stall("R1", 1'b0);
    chk("R1", if_bubble, 1'b0);
    chk("R1", redirect, 1'b0);

    // R2 R3 R4 sweep: stage, slot, src/dst 0..7, use bit, stage valid
    for (int stg = 0; stg < 3; stg++)
      for (int slot = 0; slot < 2; slot++)
        for (int a = 0; a < 8; a++)
          for (int b = 0; b < 8; b++)
            for (int e = 0; e < 2; e++)
              for (int v = 0; v < 2; v++) begin
                logic exp;
                step(); idle();
                id_valid = 1;
                if (slot == 0) begin rs1 = AW'(a); rs1_en = e[0]; rs2 = AW'(b ^ 1); rs2_en = 0; end
                else begin rs2 = AW'(a); rs2_en = e[0]; rs1 = AW'(b ^ 1); rs1_en = 0; end
                case (stg)
                  0: begin ex_valid = v[0]; ex_rd = AW'(b); end
                  1: begin mem_valid = v[0]; mem_rd = AW'(b); end
                  default: begin wb_valid = v[0]; wb_rd = AW'(b); end
                endcase
                #1;
                exp = (v == 1) && (e == 1) && (a != 0) && (a == b) && (stg != 2);
                if (stg == 2) chk("R3", if_hold, exp);
                else if (a == 0 || e == 0 || v == 0) chk("R4", if_hold, exp);
                else chk("R2", if_hold, exp);
                chk("R2", ex_bubble, exp);
                chk("R5", if_bubble, 1'b0);
              end

    // R4 invalid decode instruction never stalls
    step(); idle();
    rs1 = 5'd3; rs1_en = 1; ex_valid = 1; ex_rd = 5'd3; #1;
    check_stall("R4", 1'b0);
    // R2 full-width register, both stages at once
    step(); id_valid = 1; rs1 = 5'd31; mem_valid = 1; mem_rd = 5'd31; #1;
    check_stall("R2", 1'b1);

    // R6 R7 R8 R9 taken branch, no stalls: two bubbles then redirect
    begin
      int bubbles = 0;
      step(); idle(); if_valid = 1; if_br = 1; #1;
      chk("R6", if_bubble, 1'b1); bubbles += int'(if_bubble);
      step(); idle(); #1;
      chk("R7", if_bubble, 1'b1); bubbles += int'(if_bubble);
      step(); idle(); resolved = 1; taken = 1; #1;
      chk("R7", if_bubble, 1'b0); chk("R8", redirect, 1'b1);
      bubbles += int'(if_bubble);
      step(); idle(); #1;
      chk("R7", if_bubble, 1'b0); chk("R8", redirect, 1'b0);
      checks++;
      if (bubbles != 2) begin
        errors++; $display("FAIL R9: actual=%0d expected=2", bubbles);
      end
    end

    // R8 not-taken resolution: no redirect, freeze still released
    step(); idle(); if_valid = 1; if_br = 1; #1;
    step(); idle(); #1;
    step(); idle(); resolved = 1; taken = 0; #1;
    chk("R8", redirect, 1'b0); chk("R7", if_bubble, 1'b0);
    step(); idle(); taken = 1; #1;
    chk("R8", redirect, 1'b0);

    // R10 branch held in fetch by decode stall does not start the wait
    step(); idle(); if_valid = 1; if_br = 1; id_valid = 1; rs1 = 5'd4; rs1_en = 1;
    ex_valid = 1; ex_rd = 5'd4; #1;
    check_stall("R10", 1'b1); chk("R10", if_bubble, 1'b0);
    step(); idle(); if_valid = 1; if_br = 1; #1;  // stall cleared, branch advances
    chk("R10", if_bubble, 1'b1);
    step(); idle(); #1;
    chk("R10", if_bubble, 1'b1);
    // R7 branch stalled in decode: hold wins, freeze persists after
    step(); idle(); id_valid = 1; rs2 = 5'd9; rs2_en = 1; mem_valid = 1; mem_rd = 5'd9; #1;
    check_stall("R7", 1'b1); chk("R7", if_bubble, 1'b0);
    step(); idle(); #1;
    chk("R7", if_bubble, 1'b1);
    step(); idle(); resolved = 1; taken = 1; #1;
    chk("R7", if_bubble, 1'b0); chk("R8", redirect, 1'b1);
    step(); idle(); #1;
    chk("R7", if_bubble, 1'b0);

    summary();
  end
endmodule